// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic unit of a small 8-bit processor datapath. It takes two 8-bit operands, an operation code and a flag index. In the same cycle it produces an 8-bit result, a write-back strobe for the destination register and the next value of the status byte. The status byte is held in a register inside the block. When the operation strobe is high, the status byte takes the new value at the next rising clock edge. The register file, instruction decode and any wider arithmetic sit outside the block.

The operations cover the following:
- add and subtract, each with and without the incoming carry;
- compare with and without carry;
- bitwise AND, OR and XOR;
- one's and two's complement;
- increment and decrement;
- logical and arithmetic right shift;
- rotate left and rotate right through the carry;
- nibble exchange;
- setting or clearing any single status bit.

Each operation writes a fixed subset of the status bits and leaves every other bit as it was. This lets the surrounding code chain carries across bytes, and it lets multi-byte compares accumulate the zero flag across bytes.

Top module: `alu8_status_unit`

## Requirements
- R1: Status bits are ordered, from bit 7 down to bit 0: I, T, H, S, V, N, Z, C. A synchronous active-low reset clears all eight bits. `result`, `result_we` and `flags_next` are combinational. `status` takes `flags_next` at the rising edge when `op_en` is 1.
- R2: ADD (code 0) computes opa+opb, and ADC (code 1) computes opa+opb+C. Both update C (carry out of bit 7), H (carry out of bit 3), V (signed overflow), N (bit 7 of the result) and Z (result is zero).
- R3: SUB (2) and CMP (4) compute opa−opb; SBC (3) and CPC (5) compute opa−opb−C. All four set C to the borrow out of bit 7, H to the borrow into bit 4 from bit 3, V to signed overflow, and N to bit 7 of the result. `result_we` is 0 for CMP and CPC and 1 for SUB and SBC.
- R4: For SBC and CPC, the new Z is 1 only when the result is zero and the previous Z was also 1. SUB and CMP set Z from the result alone.
- R5: AND (6), OR (7) and XOR (8) update Z and N from the result and force V to 0. C and H keep their previous values.
- R6: INC (11) and DEC (12) add or subtract one and update only Z, N and V. V is 1 only when the operand is 0x7F for INC, or 0x80 for DEC.
- R7: COM (9) returns 0xFF−opa and sets C=1 and V=0. NEG (10) returns 0x00−opa and updates the flags as a subtraction from zero, so C=1 unless opa is 0 and V=1 only for 0x80.
- R8: LSR (13), ROL (14), ROR (15) and ASR (16) work as follows. LSR shifts in 0 at bit 7. ROL moves C into bit 0, ROR moves C into bit 7, and ASR keeps bit 7 as it was. The bit shifted out becomes the new C. Z and N come from the result, and V is set to N XOR C.
- R9: SWAP (17) exchanges bits 7..4 with bits 3..0 and leaves all eight status bits unchanged.
- R10: Every operation that updates N or V also writes S as the new N XOR the new V.
- R11: BSET (18) forces the status bit selected by `bit_sel` to 1, and BCLR (19) forces it to 0. No other status bit changes, and `result_we` is 0.
- R12: While `op_en` is 0, `status` keeps its value whatever the operation inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_en | input | 1 | Operation strobe; enables the status update at the next edge |
| op_code | input | 5 | Operation code (values listed in the requirements) |
| opa | input | 8 | Destination operand |
| opb | input | 8 | Source register or immediate operand |
| bit_sel | input | 3 | Status bit index for the set and clear operations |
| result | output | 8 | Operation result |
| result_we | output | 1 | 1 when the result is meant to be written back |
| flags_next | output | 8 | Status byte that the current operation would produce |
| status | output | 8 | Registered status byte |

## Verification
The bound checker watches several behaviours on every cycle:
- the status byte is frozen while the strobe is low and during SWAP;
- the logical and increment/decrement groups keep C and H unchanged;
- S equals N XOR V after every operation that writes N or V;
- COM leaves C set;
- set and clear operations force their selected bit.

Only the bench scenarios can show the arithmetic values themselves: the result bytes, the carry and half-carry at the bit-3 and bit-7 boundaries, the overflow cases, and the accumulation of Z across a CMP followed by CPC. The bench checks these against a reference model written with integer arithmetic. It drives random operations mixed with directed boundary cases.

// File: rtl/alu8_pkg.sv
// Shared definitions for the 8-bit ALU: operation codes and the status
// bit positions. Assumes an 8-bit status byte with a fixed bit order.
package alu8_pkg;

    localparam int OP_W   = 5;
    localparam int FLAG_W = 8;

    // Status bit positions (order is visible to software; keep it fixed)
    localparam int FB_C = 0;
    localparam int FB_Z = 1;
    localparam int FB_N = 2;
    localparam int FB_V = 3;
    localparam int FB_S = 4;
    localparam int FB_H = 5;
    localparam int FB_T = 6;
    localparam int FB_I = 7;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_CMP  = 5'd4,
        OP_CPC  = 5'd5,
        OP_AND  = 5'd6,
        OP_OR   = 5'd7,
        OP_XOR  = 5'd8,
        OP_COM  = 5'd9,
        OP_NEG  = 5'd10,
        OP_INC  = 5'd11,
        OP_DEC  = 5'd12,
        OP_LSR  = 5'd13,
        OP_ROL  = 5'd14,
        OP_ROR  = 5'd15,
        OP_ASR  = 5'd16,
        OP_SWAP = 5'd17,
        OP_BSET = 5'd18,
        OP_BCLR = 5'd19
    } alu_op_e;

endpackage

// File: rtl/alu8_addsub.sv
// Adder/subtractor shared by all add, subtract, compare and negate
// operations. Produces carry or borrow out of the top bit, the half
// carry/borrow at the nibble boundary and the signed overflow.
// Assumes DATA_W is even.
module alu8_addsub #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  logic              sub,
    output logic [DATA_W-1:0] res,
    output logic              cout,
    output logic              half,
    output logic              ovf
);
    localparam int MSB = DATA_W - 1;
    localparam int NIB = DATA_W / 2;

    logic [DATA_W:0] full;
    logic [NIB:0]    low;

    // Full-width and low-nibble sums or differences with carry/borrow in
    always_comb begin
        if (sub) begin
            full = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, cin};
            low  = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]} - {{NIB{1'b0}}, cin};
        end else begin
            full = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
            low  = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin};
        end
    end

    assign res  = full[MSB:0];
    assign cout = full[DATA_W];
    assign half = low[NIB];

    // Signed overflow from operand and result sign bits
    always_comb begin
        if (sub) ovf = (a[MSB] != b[MSB]) && (res[MSB] != a[MSB]);
        else     ovf = (a[MSB] == b[MSB]) && (res[MSB] != a[MSB]);
    end

endmodule

// File: rtl/alu8_bitops.sv
// Logical, increment/decrement, shift, rotate and nibble-swap datapath.
// cout carries the bit shifted out for the shift and rotate operations.
// Assumes DATA_W is even.
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cout
);
    localparam int MSB = DATA_W - 1;
    localparam int NIB = DATA_W / 2;

    // Operation select for the non-adder results
    always_comb begin
        res  = a;
        cout = cin;
        case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_COM:  res = ~a;
            OP_INC:  res = a + {{(DATA_W-1){1'b0}}, 1'b1};
            OP_DEC:  res = a - {{(DATA_W-1){1'b0}}, 1'b1};
            OP_LSR:  begin res = {1'b0, a[MSB:1]};   cout = a[0];   end
            OP_ROL:  begin res = {a[MSB-1:0], cin};  cout = a[MSB]; end
            OP_ROR:  begin res = {cin, a[MSB:1]};    cout = a[0];   end
            OP_ASR:  begin res = {a[MSB], a[MSB:1]}; cout = a[0];   end
            OP_SWAP: res = {a[NIB-1:0], a[MSB:NIB]};
            default: res = a;
        endcase
    end

endmodule

// File: rtl/alu8_flag_reg.sv
// Status register with a per-bit update mask. A bit whose mask is set
// takes the new value; the others keep the stored value. Loads on clk
// when load is high; synchronous active-low reset clears all bits.
module alu8_flag_reg #(
    parameter int FLAG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [FLAG_W-1:0] vals,
    input  logic [FLAG_W-1:0] mask,
    output logic [FLAG_W-1:0] merged,
    output logic [FLAG_W-1:0] status_q
);
    for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
        // Merge the new value with the held one per the mask
        assign merged[i] = mask[i] ? vals[i] : status_q[i];

        // Hold one status bit
        always_ff @(posedge clk) begin
            if (!rst_n)    status_q[i] <= 1'b0;
            else if (load) status_q[i] <= merged[i];
        end
    end

endmodule

// File: rtl/alu8_status_unit.sv
// 8-bit ALU with a registered status byte. Result, write strobe and the
// next status byte are combinational from the inputs and the stored
// flags; the status byte loads on the clock edge when op_en is high.
// Assumes unused operation codes act as no-ops (no write, no flags).
module alu8_status_unit
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_en,
    input  logic [OP_W-1:0]   op_code,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [2:0]        bit_sel,
    output logic [DATA_W-1:0] result,
    output logic              result_we,
    output logic [FLAG_W-1:0] flags_next,
    output logic [FLAG_W-1:0] status
);
    localparam int MSB = DATA_W - 1;
    localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [FLAG_W-1:0] ARITH_MASK =
        FLAG_W'((1 << FB_H) | (1 << FB_S) | (1 << FB_V) | (1 << FB_N) | (1 << FB_Z) | (1 << FB_C));
    localparam logic [FLAG_W-1:0] LOGIC_MASK =
        FLAG_W'((1 << FB_S) | (1 << FB_V) | (1 << FB_N) | (1 << FB_Z));
    localparam logic [FLAG_W-1:0] SHIFT_MASK = LOGIC_MASK | FLAG_W'(1 << FB_C);

    alu_op_e           op;
    logic [DATA_W-1:0] as_a, as_b, as_res, bo_res;
    logic              as_cin, as_sub, as_cout, as_half, as_ovf, bo_cout;
    logic              use_adder;
    logic [FLAG_W-1:0] vals, mask;

    assign op = alu_op_e'(op_code);

    // Operand and carry-in selection for the adder
    always_comb begin
        as_a   = opa;
        as_b   = opb;
        as_cin = 1'b0;
        as_sub = 1'b0;
        case (op)
            OP_ADC:         as_cin = status[FB_C];
            OP_SUB, OP_CMP: as_sub = 1'b1;
            OP_SBC, OP_CPC: begin as_sub = 1'b1; as_cin = status[FB_C]; end
            OP_NEG:         begin as_a = '0; as_b = opa; as_sub = 1'b1; end
            default: ;
        endcase
    end

    alu8_addsub #(.DATA_W(DATA_W)) addsub_i (
        .a(as_a), .b(as_b), .cin(as_cin), .sub(as_sub),
        .res(as_res), .cout(as_cout), .half(as_half), .ovf(as_ovf)
    );

    alu8_bitops #(.DATA_W(DATA_W)) bitops_i (
        .op(op), .a(opa), .b(opb), .cin(status[FB_C]),
        .res(bo_res), .cout(bo_cout)
    );

    // Result source and write-back strobe
    always_comb begin
        use_adder = op inside {OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CPC, OP_NEG};
        result    = use_adder ? as_res : bo_res;
        result_we = (op <= OP_SWAP) && !(op inside {OP_CMP, OP_CPC});
    end

    // New flag values and the set of bits each operation may change
    always_comb begin
        vals       = '0;
        mask       = '0;
        vals[FB_N] = result[MSB];
        vals[FB_Z] = (result == '0);
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_CMP, OP_NEG: begin
                mask       = ARITH_MASK;
                vals[FB_C] = as_cout;
                vals[FB_H] = as_half;
                vals[FB_V] = as_ovf;
            end
            OP_SBC, OP_CPC: begin
                mask       = ARITH_MASK;
                vals[FB_C] = as_cout;
                vals[FB_H] = as_half;
                vals[FB_V] = as_ovf;
                vals[FB_Z] = (result == '0) && status[FB_Z];
            end
            OP_AND, OP_OR, OP_XOR: mask = LOGIC_MASK;
            OP_INC: begin mask = LOGIC_MASK; vals[FB_V] = (opa == MAX_POS); end
            OP_DEC: begin mask = LOGIC_MASK; vals[FB_V] = (opa == MIN_NEG); end
            OP_COM: begin mask = SHIFT_MASK; vals[FB_C] = 1'b1; end
            OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
                mask       = SHIFT_MASK;
                vals[FB_C] = bo_cout;
                vals[FB_V] = result[MSB] ^ bo_cout;
            end
            OP_BSET: begin mask = FLAG_W'(1) << bit_sel; vals = '1; end
            OP_BCLR: begin mask = FLAG_W'(1) << bit_sel; vals = '0; end
            default: mask = '0;
        endcase
        if (!(op inside {OP_BSET, OP_BCLR}))
            vals[FB_S] = vals[FB_N] ^ vals[FB_V];
    end

    alu8_flag_reg #(.FLAG_W(FLAG_W)) flags_i (
        .clk(clk), .rst_n(rst_n), .load(op_en),
        .vals(vals), .mask(mask), .merged(flags_next), .status_q(status)
    );

endmodule

// File: rtl/alu8_status_unit_chk.sv
// Assertion checker for alu8_status_unit, bound to every instance.
// Observes the operation inputs and the registered status byte only.
module alu8_status_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_en,
    input logic [4:0] op_code,
    input logic [2:0] bit_sel,
    input logic [7:0] status
);
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !op_en |=> $stable(status)); // R12

    AST_LOGIC_KEEPS_CH: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && op_code inside {5'd6, 5'd7, 5'd8, 5'd11, 5'd12})
        |=> (status[0] == $past(status[0])) && (status[5] == $past(status[5]))); // R5

    AST_SWAP_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && op_code == 5'd17) |=> $stable(status)); // R9

    AST_SIGN_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && op_code <= 5'd16) |=> (status[4] == (status[2] ^ status[3]))); // R10

    AST_COM_SETS_C: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && op_code == 5'd9) |=> status[0]); // R7

    AST_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && op_code == 5'd18) |=> ((status & (8'h01 << $past(bit_sel))) != 8'h00)); // R11

    AST_BIT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && op_code == 5'd19) |=> ((status & (8'h01 << $past(bit_sel))) == 8'h00)); // R11

    AST_SINGLE_BIT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && op_code inside {5'd18, 5'd19}) |=> ($countones(status ^ $past(status)) <= 1)); // R11
endmodule

bind alu8_status_unit alu8_status_unit_chk chk_i (.*);

// File: tb/alu8_status_unit_tb_top.sv
// Self-checking bench: directed corner cases then seeded random operations,
// compared with a behavioural reference model written in integer arithmetic.
module alu8_status_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       op_en;
    logic [4:0] op_code;
    logic [7:0] opa, opb;
    logic [2:0] bit_sel;
    logic [7:0] result, flags_next, status;
    logic       result_we;

    int   checks = 0;
    int   errors = 0;
    logic [7:0] m_st;
    bit   done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu8_status_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_code(op_code),
        .opa(opa), .opb(opb), .bit_sel(bit_sel), .result(result),
        .result_we(result_we), .flags_next(flags_next), .status(status)
    );

    // Reference model: returns {write, result, flags}
    function automatic logic [16:0] model(input logic [4:0] op, input logic [7:0] a,
                                          input logic [7:0] b, input logic [2:0] idx,
                                          input logic [7:0] st);
        logic [7:0] f, r, x, y;
        logic       we, ci;
        int         s, h, sv;
        f = st; r = a; we = 1'b1;
        case (op)
            5'd0, 5'd1: begin
                ci = (op == 5'd1) ? st[0] : 1'b0;
                s  = int'(a) + int'(b) + int'(ci);
                h  = int'(a & 8'h0f) + int'(b & 8'h0f) + int'(ci);
                sv = int'($signed(a)) + int'($signed(b)) + int'(ci);
                r  = s[7:0];
                f[0] = (s > 255); f[5] = (h > 15); f[3] = (sv > 127 || sv < -128);
                f[2] = r[7]; f[1] = (r == 8'h00); f[4] = f[2] ^ f[3];
            end
            5'd2, 5'd3, 5'd4, 5'd5, 5'd10: begin
                x  = (op == 5'd10) ? 8'h00 : a;
                y  = (op == 5'd10) ? a : b;
                ci = (op == 5'd3 || op == 5'd5) ? st[0] : 1'b0;
                s  = int'(x) - int'(y) - int'(ci);
                h  = int'(x & 8'h0f) - int'(y & 8'h0f) - int'(ci);
                sv = int'($signed(x)) - int'($signed(y)) - int'(ci);
                r  = s[7:0];
                f[0] = (s < 0); f[5] = (h < 0); f[3] = (sv > 127 || sv < -128);
                f[2] = r[7];
                f[1] = (op == 5'd3 || op == 5'd5) ? ((r == 8'h00) && st[1]) : (r == 8'h00);
                f[4] = f[2] ^ f[3];
                we = !(op == 5'd4 || op == 5'd5);
            end
            5'd6, 5'd7, 5'd8, 5'd11, 5'd12: begin
                case (op)
                    5'd6:    r = a & b;
                    5'd7:    r = a | b;
                    5'd8:    r = a ^ b;
                    5'd11:   r = a + 8'd1;
                    default: r = a - 8'd1;
                endcase
                f[3] = (op == 5'd11) ? (a == 8'h7f) : (op == 5'd12) ? (a == 8'h80) : 1'b0;
                f[2] = r[7]; f[1] = (r == 8'h00); f[4] = f[2] ^ f[3];
            end
            5'd9: begin
                r = 8'hff - a;
                f[0] = 1'b1; f[3] = 1'b0; f[2] = r[7]; f[1] = (r == 8'h00); f[4] = f[2];
            end
            5'd13, 5'd14, 5'd15, 5'd16: begin
                case (op)
                    5'd13:   begin r = a >> 1;           f[0] = a[0]; end
                    5'd14:   begin r = {a[6:0], st[0]};  f[0] = a[7]; end
                    5'd15:   begin r = {st[0], a[7:1]};  f[0] = a[0]; end
                    default: begin r = {a[7], a[7:1]};   f[0] = a[0]; end
                endcase
                f[2] = r[7]; f[1] = (r == 8'h00); f[3] = f[2] ^ f[0]; f[4] = f[2] ^ f[3];
            end
            5'd17: r = {a[3:0], a[7:4]};
            5'd18: begin f[idx] = 1'b1; we = 1'b0; end
            5'd19: begin f[idx] = 1'b0; we = 1'b0; end
            default: we = 1'b0;
        endcase
        return {we, r, f};
    endfunction

    function automatic string tag_of(input logic [4:0] op);
        case (op)
            5'd0, 5'd1:                 return "R2";
            5'd2, 5'd3, 5'd4, 5'd5:     return "R3";
            5'd6, 5'd7, 5'd8:           return "R5";
            5'd11, 5'd12:               return "R6";
            5'd9, 5'd10:                return "R7";
            5'd13, 5'd14, 5'd15, 5'd16: return "R8";
            5'd17:                      return "R9";
            default:                    return "R11";
        endcase
    endfunction

    task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    // Apply one operation, check combinational outputs, then the latched status
    task automatic run(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic [2:0] idx, input logic en, input string tag);
        logic [16:0] e;
        @(negedge clk);
        op_code = op; opa = a; opb = b; bit_sel = idx; op_en = en;
        #1;
        e = model(op, a, b, idx, m_st);
        check(tag, "flags_next", flags_next, e[7:0]);
        check(tag, "result_we", {7'd0, result_we}, {7'd0, e[16]});
        if (e[16]) check(tag, "result", result, e[15:8]);
        @(posedge clk);
        #1;
        if (en) m_st = e[7:0];
        check(tag, "status", status, m_st);
        op_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
        end
        $finish;
    end

    initial begin
        void'($urandom(32'h1f2e3d4c));
        rst_n = 1'b0; op_en = 1'b0; op_code = '0; opa = '0; opb = '0; bit_sel = '0;
        m_st = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "reset status", status, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: half carry, carry with overflow, carry-in
        run(5'd0, 8'h0f, 8'h01, 0, 1, "R2");
        run(5'd0, 8'h80, 8'h80, 0, 1, "R2");
        run(5'd1, 8'h01, 8'h01, 0, 1, "R2");
        // R3: borrow at nibble, compare equal with no write
        run(5'd2, 8'h10, 8'h01, 0, 1, "R3");
        run(5'd4, 8'h05, 8'h05, 0, 1, "R3");
        // R4: Z accumulates across CMP then CPC
        run(5'd4, 8'h12, 8'h12, 0, 1, "R4");
        run(5'd5, 8'h00, 8'h00, 0, 1, "R4");
        run(5'd19, 0, 0, 3'd1, 1, "R4");
        run(5'd5, 8'h00, 8'h00, 0, 1, "R4");
        // R5: logical op keeps C and H
        run(5'd18, 0, 0, 3'd0, 1, "R5");
        run(5'd18, 0, 0, 3'd5, 1, "R5");
        run(5'd6, 8'hf0, 8'h0f, 0, 1, "R5");
        // R6: increment/decrement overflow edges and wrap
        run(5'd11, 8'h7f, 0, 0, 1, "R6");
        run(5'd12, 8'h80, 0, 0, 1, "R6");
        run(5'd11, 8'hff, 0, 0, 1, "R6");
        // R7: complement and negate edges
        run(5'd9, 8'h5a, 0, 0, 1, "R7");
        run(5'd10, 8'h80, 0, 0, 1, "R7");
        run(5'd10, 8'h00, 0, 0, 1, "R7");
        // R8: shifts and rotates through carry
        run(5'd18, 0, 0, 3'd0, 1, "R8");
        run(5'd15, 8'h01, 0, 0, 1, "R8");
        run(5'd14, 8'h80, 0, 0, 1, "R8");
        run(5'd16, 8'h81, 0, 0, 1, "R8");
        run(5'd13, 8'h01, 0, 0, 1, "R8");
        // R9: nibble swap with T set
        run(5'd18, 0, 0, 3'd6, 1, "R9");
        run(5'd17, 8'h3c, 0, 0, 1, "R9");
        // R10: overflow without negative gives S=1
        run(5'd2, 8'h80, 8'h01, 0, 1, "R10");
        // R11: top and bottom bit index
        run(5'd18, 0, 0, 3'd7, 1, "R11");
        run(5'd19, 0, 0, 3'd0, 1, "R11");
        // R12: idle strobe holds status
        run(5'd0, 8'hff, 8'h01, 0, 0, "R12");
        run(5'd19, 0, 0, 3'd7, 0, "R12");

        for (int i = 0; i < 400; i++) begin
            logic [4:0] op;
            logic       en;
            op = 5'($urandom % 20);
            en = ($urandom % 8) != 0;
            run(op, 8'($urandom), 8'($urandom), 3'($urandom), en, en ? tag_of(op) : "R12");
        end

        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
        end
        $finish;
    end
endmodule